// File: doc/BRIEF.md
# Recursive Doubling Prefix Engine

This block computes every inclusive prefix of a vector of P words under one of three associative operators: modular add, unsigned maximum or bitwise XOR. The whole vector comes in on a parallel load port in a single accepted cycle and is copied into an internal array of working registers. The engine then runs log2(P) doubling rounds over that array. In round r, with stride s = 2^r, each entry at index s or above is replaced by the combination of the entry s places below it and itself. Entries below the stride keep their value. Every read in a round sees the values from before that round, so updates within one round never chain.

The load side works as a single-beat valid/ready handshake. `start` is the valid signal and `busy` low is the ready signal. A beat is taken only on a cycle where `start` is high and `busy` is low. While `busy` is high, any `start` is dropped and the caller must hold off. The result side has no back-pressure: the prefix array stays on `result_vec` until the next accepted start. A one-cycle `done` pulse marks completion. The caller can also request one extra step that copies the last prefix value onto `bcast_out`.

Top module: `prefix_doubling_engine`

## Requirements
- R1: When `start` is high and `busy` is low at a rising clock edge, the engine takes `load_vec`, `op_sel` and `bcast_en`, and `busy` is high after that edge.
- R2: The operator code is `op_sel` 2'b00 for add modulo 2^W, 2'b01 for unsigned maximum, 2'b10 for bitwise XOR, and 2'b11 for add modulo 2^W. Word j of the vector sits in bits [j*W +: W].
- R3: At completion, word j of `result_vec` equals x0 op x1 op ... op xj, computed from the loaded words.
- R4: Word 0 of `result_vec` at completion equals loaded word 0, since entries below the stride never change.
- R5: Within a round every update reads pre-round values. For example, an all-ones vector under add gives word j = (j+1)*(2^W-1) mod 2^W.
- R6: `done` rises exactly log2(P) clock edges after the accepting edge, or log2(P)+1 edges when broadcast was requested. `busy` stays high up to that point.
- R7: `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R8: While `busy` is low and no start is accepted, `result_vec` and `bcast_out` hold their values.
- R9: A `start` raised while `busy` is high is ignored. The running job finishes with its own data, operator and broadcast choice.
- R10: If broadcast was requested, `bcast_out` equals the final word P-1 when `done` is high. Otherwise `bcast_out` is 0, because it is cleared at the accepting edge.
- R11: After reset, `busy`, `done`, `result_vec` and `bcast_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load request (valid) |
| op_sel | input | 2 | Operator code, sampled on accept |
| bcast_en | input | 1 | Request final broadcast step, sampled on accept |
| load_vec | input | P*W | Input vector, word j at [j*W +: W] |
| busy | output | 1 | Job in progress; low means ready |
| done | output | 1 | One-cycle completion pulse |
| result_vec | output | P*W | Prefix array, word j at [j*W +: W] |
| bcast_out | output | W | Copy of the last prefix word after broadcast |

## Verification
Results are due log2(P) edges after the accepting edge, or one edge later when broadcast was requested. `busy` is due one edge after acceptance, and `done` falls one edge after it rises. The bench drives inputs on falling edges and samples at the following falling edge after each rising edge it counts. On every cycle before the due edge it confirms that `done` is still low. On the due cycle it compares `result_vec` and `bcast_out` against a serial reference scan. It then confirms that the outputs hold over idle cycles. Jobs that receive a start while busy are still compared against the data of the original load.

// File: rtl/prefix_pkg.sv
package prefix_pkg;
  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_MAX     = 2'b01,
    OP_XOR     = 2'b10,
    OP_ADD_ALT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RUN   = 2'b01,
    ST_BCAST = 2'b10
  } state_e;
endpackage

// File: rtl/prefix_combine.sv
module prefix_combine
  import prefix_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_MAX:  y = (lo > hi) ? lo : hi;
      OP_XOR:  y = lo ^ hi;
      default: y = lo + hi;
    endcase
  end
endmodule

// File: rtl/prefix_round_net.sv
module prefix_round_net
  import prefix_pkg::*;
#(
  parameter int P    = 8,
  parameter int W    = 16,
  parameter int LOGP = $clog2(P)
) (
  input  logic [P*W-1:0]  cur,
  input  logic [LOGP-1:0] round_idx,
  input  op_e             op,
  output logic [P*W-1:0]  nxt
);
  // cand[j][r]: value of entry j if round r (stride 2^r) is applied
  logic [W-1:0] cand [P][LOGP];

  for (genvar j = 0; j < P; j++) begin : g_entry
    for (genvar r = 0; r < LOGP; r++) begin : g_round
      if (j >= (1 << r)) begin : g_upd
        prefix_combine #(.W(W)) u_comb (
          .op (op),
          .lo (cur[(j - (1 << r))*W +: W]),
          .hi (cur[j*W +: W]),
          .y  (cand[j][r])
        );
      end else begin : g_keep
        assign cand[j][r] = cur[j*W +: W];
      end
    end

    always_comb begin
      nxt[j*W +: W] = cur[j*W +: W];
      for (int r = 0; r < LOGP; r++) begin
        if (round_idx == LOGP'(r)) nxt[j*W +: W] = cand[j][r];
      end
    end
  end
endmodule

// File: rtl/prefix_seq_ctrl.sv
module prefix_seq_ctrl
  import prefix_pkg::*;
#(
  parameter int LOGP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op_sel,
  input  logic            bcast_en,
  output logic            load_en,
  output logic            round_en,
  output logic            bcast_step,
  output logic [LOGP-1:0] round_idx,
  output op_e             op_q,
  output logic            busy,
  output logic            done
);
  state_e          state_q;
  logic [LOGP-1:0] rnd_q;
  logic            bc_q;
  logic            done_q;
  logic            last_round;

  assign last_round = (rnd_q == LOGP'(LOGP - 1));
  assign load_en    = (state_q == ST_IDLE) && start;
  assign round_en   = (state_q == ST_RUN);
  assign bcast_step = (state_q == ST_BCAST);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign round_idx  = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      bc_q    <= 1'b0;
      op_q    <= OP_ADD;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            rnd_q   <= '0;
            bc_q    <= bcast_en;
            op_q    <= op_e'(op_sel);
          end
        end
        ST_RUN: begin
          if (last_round) begin
            if (bc_q) begin
              state_q <= ST_BCAST;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end else begin
            rnd_q <= rnd_q + 1'b1;
          end
        end
        ST_BCAST: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prefix_doubling_engine.sv
module prefix_doubling_engine
  import prefix_pkg::*;
#(
  parameter int P = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     op_sel,
  input  logic           bcast_en,
  input  logic [P*W-1:0] load_vec,
  output logic           busy,
  output logic           done,
  output logic [P*W-1:0] result_vec,
  output logic [W-1:0]   bcast_out
);
  // P must be a power of two, at least 2
  localparam int LOGP = $clog2(P);

  logic            load_en;
  logic            round_en;
  logic            bcast_step;
  logic [LOGP-1:0] round_idx;
  op_e             op_q;
  logic [P*W-1:0]  work_q;
  logic [P*W-1:0]  work_nxt;
  logic [W-1:0]    bc_q;

  prefix_seq_ctrl #(.LOGP(LOGP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_sel     (op_sel),
    .bcast_en   (bcast_en),
    .load_en    (load_en),
    .round_en   (round_en),
    .bcast_step (bcast_step),
    .round_idx  (round_idx),
    .op_q       (op_q),
    .busy       (busy),
    .done       (done)
  );

  prefix_round_net #(.P(P), .W(W), .LOGP(LOGP)) u_net (
    .cur       (work_q),
    .round_idx (round_idx),
    .op        (op_q),
    .nxt       (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      bc_q   <= '0;
    end else begin
      if (load_en) begin
        work_q <= load_vec;
        bc_q   <= '0;
      end else if (round_en) begin
        work_q <= work_nxt;
      end else if (bcast_step) begin
        bc_q <= work_q[(P-1)*W +: W];
      end
    end
  end

  assign result_vec = work_q;
  assign bcast_out  = bc_q;
endmodule

// File: rtl/prefix_engine_checker.sv
module prefix_engine_checker #(
  parameter int P = 8,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           bcast_en,
  input logic [P*W-1:0] load_vec,
  input logic           busy,
  input logic           done,
  input logic [P*W-1:0] result_vec,
  input logic [W-1:0]   bcast_out
);
  localparam int LOGP = $clog2(P);

  logic [7:0]   cyc_q;
  logic         bq_q;
  logic [W-1:0] x0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      bq_q  <= 1'b0;
      x0_q  <= '0;
    end else if (start && !busy) begin
      cyc_q <= '0;
      bq_q  <= bcast_en;
      x0_q  <= load_vec[W-1:0];
    end else if (busy) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_run_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == 8'(LOGP + int'(bq_q))));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result_vec) && $stable(bcast_out)));
  assert_entry0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result_vec[W-1:0] == x0_q));
  assert_bcast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bcast_out == (bq_q ? result_vec[(P-1)*W +: W] : '0)));
endmodule

bind prefix_doubling_engine prefix_engine_checker #(.P(P), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .bcast_en   (bcast_en),
  .load_vec   (load_vec),
  .busy       (busy),
  .done       (done),
  .result_vec (result_vec),
  .bcast_out  (bcast_out)
);

// File: tb/test_prefix_doubling_engine.sv
`timescale 1ns/1ps
module test_prefix_doubling_engine;
  localparam int P = 8;
  localparam int W = 16;
  localparam int L = 3;
  localparam int VW = P*W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op_sel = 2'b00;
  logic          bcast_en = 1'b0;
  logic [VW-1:0] load_vec = '0;
  logic          busy;
  logic          done;
  logic [VW-1:0] result_vec;
  logic [W-1:0]  bcast_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prefix_doubling_engine #(.P(P), .W(W)) i_prefix_doubling_engine (
    .clk, .rst_n, .start, .op_sel, .bcast_en, .load_vec,
    .busy, .done, .result_vec, .bcast_out
  );

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] f_op(input logic [1:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    case (op)
      2'b01:   return (a > b) ? a : b;
      2'b10:   return a ^ b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [VW-1:0] ref_scan(input logic [VW-1:0] x, input logic [1:0] op);
    logic [VW-1:0] r;
    logic [W-1:0]  acc;
    acc = x[W-1:0];
    r[W-1:0] = acc;
    for (int j = 1; j < P; j++) begin
      acc = f_op(op, acc, x[j*W +: W]);
      r[j*W +: W] = acc;
    end
    return r;
  endfunction

  task automatic run_job(input logic [VW-1:0] x, input logic [1:0] op, input bit bc,
                         input bit poke, input string tag);
    logic [VW-1:0] exp_v;
    logic [VW-1:0] held;
    logic [W-1:0]  exp_b;
    exp_v = ref_scan(x, op);
    exp_b = bc ? exp_v[(P-1)*W +: W] : '0;
    @(negedge clk);
    load_vec = x; op_sel = op; bcast_en = bc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, {"R1 busy after accept ", tag},
        VW'({busy, done}), VW'(2'b10));
    if (poke) begin
      start = 1'b1; load_vec = ~x; op_sel = op ^ 2'b01; bcast_en = !bc;
    end
    for (int k = 1; k < L + int'(bc); k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, {"R6 early done ", tag},
          VW'({busy, done}), VW'(2'b10));
    end
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, {"R6 R7 done due ", tag},
        VW'({busy, done}), VW'(2'b01));
    chk(result_vec === exp_v, {poke ? "R9 R3 result " : "R3 R2 result ", tag},
        result_vec, exp_v);
    chk(result_vec[W-1:0] === x[W-1:0], {"R4 word0 ", tag},
        VW'(result_vec[W-1:0]), VW'(x[W-1:0]));
    chk(bcast_out === exp_b, {"R10 bcast ", tag}, VW'(bcast_out), VW'(exp_b));
    held = result_vec;
    load_vec = ~x;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(done === 1'b0, {"R7 done pulse ", tag}, VW'(done), VW'(0));
      chk(result_vec === held && bcast_out === exp_b, {"R8 hold ", tag},
          result_vec, held);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result_vec === '0 && bcast_out === '0,
        "R11 reset state", result_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);

    v = '1;
    run_job(v, 2'b00, 1'b0, 1'b0, "R5 all ones add");
    for (int j = 0; j < P; j++) v[j*W +: W] = W'(j + 1);
    run_job(v, 2'b00, 1'b1, 1'b0, "R2 add ramp bc");
    run_job(v, 2'b11, 1'b0, 1'b0, "R2 code3 add");
    for (int j = 0; j < P; j++) v[j*W +: W] = W'((j * 37) ^ 16'h5a5a);
    run_job(v, 2'b01, 1'b1, 1'b0, "R2 max");
    run_job(v, 2'b10, 1'b0, 1'b0, "R2 xor");
    run_job('0, 2'b01, 1'b1, 1'b0, "zeros max");
    run_job(v, 2'b10, 1'b1, 1'b1, "R9 poke");

    for (int n = 0; n < 40; n++) begin
      for (int j = 0; j < P; j++) v[j*W +: W] = W'($urandom);
      run_job(v, 2'($urandom % 4), 1'($urandom % 2), ($urandom % 4) == 0, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule